// File: doc/BRIEF.md
# Adaptive Half-Bridge Gate Sequencer

This block is the digital core of a half-bridge gate controller. It turns two active-high command lines, one for the high-side switch and one for the low-side switch, into two gate-enable outputs. The two switches are never enabled at the same moment. The gap between one switch turning off and the other turning on is not a fixed count of cycles. Instead the block holds the incoming switch off until a per-gate "discharged" status confirms that the outgoing gate has really collapsed. This lets the gap stretch or shrink to suit the power devices that are fitted.

Two supply-health flags gate the outputs. A fault on the main supply shuts both channels. A fault on the floating high-side supply shuts only the high side, and the low side carries on as normal. An active-low status line, in the style of an open-drain output, reports the main-supply fault. A timeout counter with a run-time limit raises a fault flag when a discharged status fails to arrive in time. While that flag is raised, the waiting gate stays off. Every status and command input is resynchronised by a two-stage flop chain before it is used.

Top module: `hb_interlock`

## Requirements
- R1: While `rst` is high, and at the first sample after reset, `gate_hi_o`=0, `gate_lo_o`=0, `fault_o`=0 and `uv_stat_n_o`=1.
- R2: With both discharged inputs at 1, `cmd_hi_i` alone high turns `gate_hi_o` on at the 4th rising edge after the input changes. `cmd_lo_i` alone high does the same for `gate_lo_o`. Dropping the command turns the gate off at the 3rd rising edge. With no command high, both gates are off.
- R3: When `cmd_hi_i` and `cmd_lo_i` are both high, both gate outputs are held at 0. Each command therefore blocks the other.
- R4: `gate_hi_o` and `gate_lo_o` are never 1 in the same cycle.
- R5: `gate_hi_o` does not turn on while the resynchronised `lo_dis_i` is 0, and `gate_lo_o` does not turn on while the resynchronised `hi_dis_i` is 0. The gate turns on at the 3rd rising edge after the discharged input rises.
- R6: When the command moves from one side to the other, the active gate turns off first, at the 3rd edge. The other gate is enabled only after the discharged status of the gate that just turned off has been seen.
- R7: While `uv_main_i` is 1, both gate outputs are 0. They are forced low at the 3rd edge after it rises.
- R8: While `uv_float_i` is 1, `gate_hi_o` is 0, and the low-side channel keeps following `cmd_lo_i`.
- R9: `uv_stat_n_o` is 0 while `uv_main_i` is 1, following it with a 3-edge latency, and is 1 otherwise.
- R10: When `tmo_limit_i` is N, with N nonzero, and a gate has waited N cycles for its discharged status, `fault_o` rises. While `fault_o` is 1 the waiting gate stays off, even if the status then arrives. `fault_o` clears once the command is withdrawn. When `tmo_limit_i` is 0, the timeout is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi_i | input | 1 | High-side command, active high, asynchronous |
| cmd_lo_i | input | 1 | Low-side command, active high, asynchronous |
| hi_dis_i | input | 1 | High-side gate discharged status, 1 = discharged |
| lo_dis_i | input | 1 | Low-side gate discharged status, 1 = discharged |
| uv_main_i | input | 1 | Main supply undervoltage, 1 = fault |
| uv_float_i | input | 1 | Floating supply undervoltage, 1 = fault |
| tmo_limit_i | input | TMO_W | Discharge wait limit in cycles, 0 = no timeout; change only while both gates are idle |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |
| uv_stat_n_o | output | 1 | Undervoltage status, active low (open-drain style) |
| fault_o | output | 1 | Discharge timeout fault |

## Verification
The properties are written against the resynchronised inputs rather than the raw pins. Their only assumption about the pins is that each one is a clean level that holds long enough to pass the two-flop chain. The stimulus changes every input on the falling edge and holds it for at least several cycles. The timeout limit is treated as static, so the bench changes `tmo_limit_i` only while both gates are idle and no command is pending. The discharged inputs are driven by hand to model slow and missing gate collapse: the bench does not tie them to the gate outputs.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_HI = 3'd1,
        ST_HI      = 3'd2,
        ST_WAIT_LO = 3'd3,
        ST_LO      = 3'd4
    } hb_state_e;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_HI   = 2'd1,
        REQ_LO   = 2'd2
    } hb_req_e;

    typedef struct packed {
        logic cmd_hi;
        logic cmd_lo;
        logic hi_dis;
        logic lo_dis;
        logic uv_main;
        logic uv_float;
    } hb_in_s;

    localparam int HB_IN_W = $bits(hb_in_s);

    // Resolve commands and supply flags into a single side request.
    function automatic hb_req_e hb_decode(input hb_in_s x);
        hb_req_e r;
        r = REQ_NONE;
        if (!x.uv_main) begin
            if (x.cmd_hi && !x.cmd_lo && !x.uv_float)
                r = REQ_HI;
            else if (x.cmd_lo && !x.cmd_hi)
                r = REQ_LO;
        end
        return r;
    endfunction

    function automatic logic hb_is_wait(input hb_state_e s);
        return (s == ST_WAIT_HI) || (s == ST_WAIT_LO);
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= '0;
            else     chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain_q[LAST];
    end

endmodule

// File: rtl/hb_wait_timer.sv
module hb_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_wait_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             fault_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!in_wait_i || restart_i)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign fault_o = in_wait_i && (limit_i != '0) && (cnt_q >= limit_i);

endmodule

// File: rtl/hb_seq.sv
module hb_seq
    import hb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hb_req_e   req_i,
    input  logic      hi_dis_i,
    input  logic      lo_dis_i,
    input  logic      fault_i,
    output hb_state_e state_o,
    output logic      in_wait_o,
    output logic      restart_o,
    output logic      gate_hi_o,
    output logic      gate_lo_o
);
    hb_state_e state_q, state_d;
    logic      gate_hi_q, gate_lo_q;

    // Where to go when the current request no longer matches this side.
    function automatic hb_state_e leave(input hb_req_e r);
        case (r)
            REQ_HI:  return ST_WAIT_HI;
            REQ_LO:  return ST_WAIT_LO;
            default: return ST_IDLE;
        endcase
    endfunction

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    state_d = leave(req_i);
            ST_WAIT_HI: begin
                if (req_i != REQ_HI)            state_d = leave(req_i);
                else if (lo_dis_i && !fault_i)  state_d = ST_HI;
            end
            ST_HI:      if (req_i != REQ_HI) state_d = leave(req_i);
            ST_WAIT_LO: begin
                if (req_i != REQ_LO)            state_d = leave(req_i);
                else if (hi_dis_i && !fault_i)  state_d = ST_LO;
            end
            ST_LO:      if (req_i != REQ_LO) state_d = leave(req_i);
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            gate_hi_q <= 1'b0;
            gate_lo_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            gate_hi_q <= (state_d == ST_HI);
            gate_lo_q <= (state_d == ST_LO);
        end
    end

    assign state_o   = state_q;
    assign in_wait_o = hb_is_wait(state_q);
    assign restart_o = (state_d != state_q);
    assign gate_hi_o = gate_hi_q;
    assign gate_lo_o = gate_lo_q;

endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
    import hb_pkg::*;
#(
    parameter int TMO_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_hi_i,
    input  logic             cmd_lo_i,
    input  logic             hi_dis_i,
    input  logic             lo_dis_i,
    input  logic             uv_main_i,
    input  logic             uv_float_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    output logic             gate_hi_o,
    output logic             gate_lo_o,
    output logic             uv_stat_n_o,
    output logic             fault_o
);
    hb_in_s            in_raw, in_s;
    logic [HB_IN_W-1:0] in_s_vec;
    hb_req_e           req;
    hb_state_e         state;
    logic              in_wait, restart, tmo_fault;
    logic              uv_stat_n_q;

    assign in_raw = '{cmd_hi:   cmd_hi_i,
                      cmd_lo:   cmd_lo_i,
                      hi_dis:   hi_dis_i,
                      lo_dis:   lo_dis_i,
                      uv_main:  uv_main_i,
                      uv_float: uv_float_i};

    hb_sync #(.W(HB_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (in_raw),
        .q_o (in_s_vec)
    );
    assign in_s = hb_in_s'(in_s_vec);
    assign req  = hb_decode(in_s);

    hb_wait_timer #(.CNT_W(TMO_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .in_wait_i (in_wait),
        .restart_i (restart),
        .limit_i   (tmo_limit_i),
        .fault_o   (tmo_fault)
    );

    hb_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req),
        .hi_dis_i  (in_s.hi_dis),
        .lo_dis_i  (in_s.lo_dis),
        .fault_i   (tmo_fault),
        .state_o   (state),
        .in_wait_o (in_wait),
        .restart_o (restart),
        .gate_hi_o (gate_hi_o),
        .gate_lo_o (gate_lo_o)
    );

    always_ff @(posedge clk) begin
        if (rst) uv_stat_n_q <= 1'b1;
        else     uv_stat_n_q <= ~in_s.uv_main;
    end

    assign uv_stat_n_o = uv_stat_n_q;
    assign fault_o     = tmo_fault;

endmodule

// File: rtl/hb_interlock_chk.sv
module hb_interlock_chk
    import hb_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input hb_in_s in_s,
    input logic   gate_hi_o,
    input logic   gate_lo_o,
    input logic   uv_stat_n_o,
    input logic   fault_o
);
    AST_NO_DUAL_ON: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi_o && gate_lo_o)); // R4

    AST_HI_AFTER_LO_DIS: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi_o) |-> $past(in_s.lo_dis) && $past(!gate_lo_o)); // R5

    AST_LO_AFTER_HI_DIS: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo_o) |-> $past(in_s.hi_dis) && $past(!gate_hi_o)); // R6

    AST_BOTH_CMD_OFF: assert property (@(posedge clk) disable iff (rst)
        (in_s.cmd_hi && in_s.cmd_lo) |=> !gate_hi_o && !gate_lo_o); // R3

    AST_MAIN_UV_OFF: assert property (@(posedge clk) disable iff (rst)
        in_s.uv_main |=> !gate_hi_o && !gate_lo_o); // R7

    AST_FLOAT_UV_TOP_OFF: assert property (@(posedge clk) disable iff (rst)
        in_s.uv_float |=> !gate_hi_o); // R8

    AST_UV_STATUS_LOW: assert property (@(posedge clk) disable iff (rst)
        in_s.uv_main |=> !uv_stat_n_o); // R9

    AST_FAULT_KEEPS_OFF: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> !gate_hi_o && !gate_lo_o); // R10

endmodule

bind hb_interlock hb_interlock_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_s        (in_s),
    .gate_hi_o   (gate_hi_o),
    .gate_lo_o   (gate_lo_o),
    .uv_stat_n_o (uv_stat_n_o),
    .fault_o     (fault_o)
);

// File: tb/tb_hb_interlock.sv
module tb_hb_interlock;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_hi, cmd_lo, hi_dis, lo_dis, uv_main, uv_float;
    logic [TMO_W-1:0] tmo_limit;
    logic             gate_hi, gate_lo, uv_stat_n, fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hb_interlock #(.TMO_W(TMO_W)) dut (
        .clk         (clk),
        .rst         (rst),
        .cmd_hi_i    (cmd_hi),
        .cmd_lo_i    (cmd_lo),
        .hi_dis_i    (hi_dis),
        .lo_dis_i    (lo_dis),
        .uv_main_i   (uv_main),
        .uv_float_i  (uv_float),
        .tmo_limit_i (tmo_limit),
        .gate_hi_o   (gate_hi),
        .gate_lo_o   (gate_lo),
        .uv_stat_n_o (uv_stat_n),
        .fault_o     (fault)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Advance n rising edges, then sit on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        cmd_hi = 0; cmd_lo = 0; uv_main = 0; uv_float = 0;
        hi_dis = 1; lo_dis = 1;
        step(6);
    endtask

    task automatic t_reset();
        rst = 1; cmd_hi = 0; cmd_lo = 0; hi_dis = 1; lo_dis = 1;
        uv_main = 0; uv_float = 0; tmo_limit = '0;
        step(3);
        chk("R1", "gate_hi in reset", gate_hi, 1'b0);
        chk("R1", "gate_lo in reset", gate_lo, 1'b0);
        chk("R1", "fault in reset", fault, 1'b0);
        chk("R1", "uv_stat_n in reset", uv_stat_n, 1'b1);
        rst = 0;
        step(0);
        chk("R1", "gate_hi after reset", gate_hi, 1'b0);
        chk("R1", "gate_lo after reset", gate_lo, 1'b0);
    endtask

    task automatic t_single();
        cmd_hi = 1;
        step(3);
        chk("R2", "top not yet on at edge 3", gate_hi, 1'b0);
        step(1);
        chk("R2", "top on at edge 4", gate_hi, 1'b1);
        chk("R2", "bottom off with top cmd", gate_lo, 1'b0);
        cmd_hi = 0;
        step(2);
        chk("R2", "top still on at edge 2", gate_hi, 1'b1);
        step(1);
        chk("R2", "top off at edge 3", gate_hi, 1'b0);
        cmd_lo = 1;
        step(4);
        chk("R2", "bottom on at edge 4", gate_lo, 1'b1);
        chk("R2", "top off with bottom cmd", gate_hi, 1'b0);
        cmd_lo = 0;
        step(5);
        chk("R2", "no cmd bottom off", gate_lo, 1'b0);
        chk("R2", "no cmd top off", gate_hi, 1'b0);
    endtask

    task automatic t_both();
        cmd_hi = 1;
        step(6);
        cmd_lo = 1;
        step(6);
        chk("R3", "both cmds: top held low", gate_hi, 1'b0);
        chk("R3", "both cmds: bottom held low", gate_lo, 1'b0);
        cmd_hi = 0;
        step(6);
        chk("R3", "top released: bottom on", gate_lo, 1'b1);
        go_idle();
    endtask

    task automatic t_handover();
        cmd_hi = 1;
        step(6);
        chk("R6", "top on before handover", gate_hi, 1'b1);
        hi_dis = 0; cmd_hi = 0; cmd_lo = 1;
        step(2);
        chk("R6", "top still on at edge 2", gate_hi, 1'b1);
        step(1);
        chk("R6", "top turned off first", gate_hi, 1'b0);
        chk("R6", "bottom not yet on", gate_lo, 1'b0);
        step(20);
        chk("R5", "bottom inhibited without top discharged", gate_lo, 1'b0);
        chk("R4", "neither gate on while waiting", gate_hi | gate_lo, 1'b0);
        hi_dis = 1;
        step(2);
        chk("R5", "bottom off 2 edges after discharged", gate_lo, 1'b0);
        step(1);
        chk("R5", "bottom on 3 edges after discharged", gate_lo, 1'b1);
        lo_dis = 0; cmd_lo = 0; cmd_hi = 1;
        step(15);
        chk("R5", "top inhibited without bottom discharged", gate_hi, 1'b0);
        lo_dis = 1;
        step(3);
        chk("R6", "top on after bottom discharged", gate_hi, 1'b1);
        go_idle();
    endtask

    task automatic t_uv_main();
        cmd_hi = 1;
        step(6);
        uv_main = 1;
        step(2);
        chk("R9", "status still high at edge 2", uv_stat_n, 1'b1);
        step(1);
        chk("R7", "top forced off", gate_hi, 1'b0);
        chk("R9", "status low under main uv", uv_stat_n, 1'b0);
        cmd_hi = 0; cmd_lo = 1;
        step(8);
        chk("R7", "bottom forced off", gate_lo, 1'b0);
        uv_main = 0;
        step(6);
        chk("R7", "bottom resumes", gate_lo, 1'b1);
        chk("R9", "status released", uv_stat_n, 1'b1);
        go_idle();
    endtask

    task automatic t_uv_float();
        cmd_lo = 1;
        step(6);
        uv_float = 1;
        step(6);
        chk("R8", "bottom keeps running", gate_lo, 1'b1);
        chk("R9", "status unaffected by float uv", uv_stat_n, 1'b1);
        cmd_lo = 0; cmd_hi = 1;
        step(8);
        chk("R8", "top blocked under float uv", gate_hi, 1'b0);
        uv_float = 0;
        step(6);
        chk("R8", "top on after float uv clears", gate_hi, 1'b1);
        uv_float = 1;
        step(3);
        chk("R8", "top forced off by float uv", gate_hi, 1'b0);
        go_idle();
    endtask

    task automatic t_timeout();
        tmo_limit = 8'd5;
        lo_dis = 0; cmd_hi = 1;
        step(20);
        chk("R10", "fault raised after limit", fault, 1'b1);
        chk("R10", "top off during fault", gate_hi, 1'b0);
        lo_dis = 1;
        step(10);
        chk("R10", "top stays off after late discharge", gate_hi, 1'b0);
        chk("R10", "fault held", fault, 1'b1);
        cmd_hi = 0;
        step(6);
        chk("R10", "fault clears on withdraw", fault, 1'b0);
        cmd_hi = 1;
        step(6);
        chk("R10", "prompt discharge within limit", gate_hi, 1'b1);
        chk("R10", "no fault on prompt discharge", fault, 1'b0);
        go_idle();
        tmo_limit = '0;
        lo_dis = 0; cmd_hi = 1;
        step(300);
        chk("R10", "limit 0 never faults", fault, 1'b0);
        lo_dis = 1;
        step(4);
        chk("R10", "limit 0 top on after discharge", gate_hi, 1'b1);
        go_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_both();
        t_handover();
        t_uv_main();
        t_uv_float();
        t_timeout();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule